// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the sequencing core of an on-chip debug trigger. It walks through three intermediate steps (State1, State2, State3) and a terminal Final step as comparator match pulses arrive on three match channels numbered 0, 1 and 2. Each intermediate step owns a 4-bit routing code. The code says which channel moves the sequencer to which next step. Matches that the code does not route are ignored. When several routed matches land in the same cycle, a route to Final beats every other route, and among the others the lowest channel number wins.

Software drives the block over a small register bus. A control register holds the arm bit and a 2-bit bank select. One window address exposes the routing code of the step chosen by the bank select. A third register holds one enable bit per match channel. Routing codes are locked while the sequencer is armed. Reaching Final raises a one-cycle trigger pulse and a sticky flag, and both are cleared by the next arm.

Top module: `dbgseq_top`

## Requirements
- R1: After reset, `armed_o`, `trig_o` and `final_o` are 0, `state_o` is 0 (idle), and every register reads 0.
- R2: The bus map at default addresses is as follows. Address 0 is the control register: bit 7 is arm and bits 1:0 are the bank select. Address 1 is the window: bits 3:0 hold the routing code of State1, State2 or State3 for a bank select of 00, 01 or 10, and bits 7:4 read 0. A bank select of 11 reads 0 and drops window writes. Address 2 holds the channel enables in bits 2:0. Address 3 reads 0. Reads are combinational.
- R3: A window write while armed leaves the selected routing code unchanged. A window write while idle stores the code.
- R4: A control write with bit 7 = 1 while idle arms the sequencer, and `state_o` is 1 (State1) after that clock edge. A control write with bit 7 = 0 disarms it, and `state_o` is 0. `state_o` is 0 exactly when the sequencer is not armed. The `state_o` codes are: 0 idle, 1 State1, 2 State2, 3 State3, 4 Final.
- R5: Each routing code maps channels to targets. For the current step, LO is the lower-numbered of the other two intermediate steps and HI is the higher-numbered one. The codes are: 0001 ch0→LO; 0010 ch1→LO; 0011 ch2→LO; 0100 ch0→HI; 0101 ch1→HI; 0110 ch2→HI; 0111 ch0→LO and ch2→HI; 1000 ch1→LO and ch2→HI; 1001 ch0→Final; 1010 ch1→Final; 1011 ch2→Final; 1100 ch0→Final and ch1→HI; 1101 ch0 or ch2→Final and ch1→LO. A routed match changes `state_o` at the clock edge that ends its cycle.
- R6: A match on a channel that the current code does not route has no effect. Codes 0000, 1110 and 1111 route nothing.
- R7: A match on a channel whose enable bit is 0 has no effect.
- R8: When several routed matches arrive in the same cycle, a route to Final wins. Otherwise the lowest channel wins. For example, with State1 code 1101, ch0 and ch1 together give Final, and ch1 and ch2 together also give Final.
- R9: Entering Final sets `trig_o` for exactly one cycle and sets `final_o`. While in Final, matches have no effect. `final_o` survives a disarm and clears on the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| match_i | input | 3 | Single-cycle match pulses, one per channel |
| armed_o | output | 1 | Sequencer is armed |
| state_o | output | 3 | Current step code (0 idle, 1–3 State1–3, 4 Final) |
| trig_o | output | 1 | One-cycle pulse on entering Final |
| final_o | output | 1 | Sticky Final flag |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, a 2-bit address, and the control, window and enable registers at addresses 0, 1 and 2. At this width the unimplemented upper window bits and the unused fourth address can be seen directly, so the zero-read rules are checked at the ports. With three-step banking reachable through the select field, the bench programs different codes per step and runs full walks from State1 to Final. It also runs same-cycle match pairs that exercise both arbitration rules and the enable and routing filters.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

   localparam int unsigned N_CH    = 3;
   localparam int unsigned FIELD_W = 4;
   localparam int unsigned N_STEP  = 3;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_S1    = 3'd1,
      ST_S2    = 3'd2,
      ST_S3    = 3'd3,
      ST_FINAL = 3'd4
   } seq_st_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_LO   = 2'd1,
      TGT_HI   = 2'd2,
      TGT_FIN  = 2'd3
   } tgt_e;

   // routing word {ch2, ch1, ch0}, two bits per channel
   function automatic logic [2*N_CH-1:0] route_of(input logic [FIELD_W-1:0] code);
      logic [2*N_CH-1:0] r;
      case (code)
         4'b0001: r = 6'b00_00_01;
         4'b0010: r = 6'b00_01_00;
         4'b0011: r = 6'b01_00_00;
         4'b0100: r = 6'b00_00_10;
         4'b0101: r = 6'b00_10_00;
         4'b0110: r = 6'b10_00_00;
         4'b0111: r = 6'b10_00_01;
         4'b1000: r = 6'b10_01_00;
         4'b1001: r = 6'b00_00_11;
         4'b1010: r = 6'b00_11_00;
         4'b1011: r = 6'b11_00_00;
         4'b1100: r = 6'b00_10_11;
         4'b1101: r = 6'b11_01_11;
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic seq_st_e resolve(input seq_st_e cur, input tgt_e t);
      seq_st_e d;
      case (t)
         TGT_FIN: d = ST_FINAL;
         TGT_LO:  d = (cur == ST_S1) ? ST_S2 : ST_S1;
         TGT_HI:  d = (cur == ST_S3) ? ST_S2 : ST_S3;
         default: d = cur;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/dbgseq_regs.sv
module dbgseq_regs
   import dbgseq_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned CTRL_ADDR = 0,
   parameter int unsigned WIN_ADDR  = 1,
   parameter int unsigned EN_ADDR   = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [DATA_W-1:0]                wdata,
   output logic [DATA_W-1:0]                rdata,
   output logic                             armed,
   output logic                             arm_set,
   output logic                             arm_clr,
   output logic [N_STEP-1:0][FIELD_W-1:0]   fld,
   output logic [N_CH-1:0]                  en
);

   localparam int unsigned ARM_BIT = 7;
   localparam int unsigned SEL_W   = 2;
   localparam int unsigned REG_W   = 8;

   logic                 armed_q;
   logic [SEL_W-1:0]     sel_q;
   logic [N_CH-1:0]      en_q;
   logic [N_STEP-1:0][FIELD_W-1:0] fld_q;
   logic                 hit_ctrl, hit_win, hit_en;
   logic [REG_W-1:0]     rd8;

   assign hit_ctrl = addr == ADDR_W'(CTRL_ADDR);
   assign hit_win  = addr == ADDR_W'(WIN_ADDR);
   assign hit_en   = addr == ADDR_W'(EN_ADDR);

   assign arm_set = wr && hit_ctrl &&  wdata[ARM_BIT] && !armed_q;
   assign arm_clr = wr && hit_ctrl && !wdata[ARM_BIT] &&  armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         sel_q   <= '0;
         en_q    <= '0;
      end else begin
         if (wr && hit_ctrl) begin
            sel_q <= wdata[SEL_W-1:0];
            if (arm_set) armed_q <= 1'b1;
            if (arm_clr) armed_q <= 1'b0;
         end
         if (wr && hit_en) en_q <= wdata[N_CH-1:0];
      end
   end

   for (genvar j = 0; j < N_STEP; j++) begin : g_step
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fld_q[j] <= '0;
         else if (wr && hit_win && !armed_q && sel_q == SEL_W'(j))
            fld_q[j] <= wdata[FIELD_W-1:0];
      end
   end

   always_comb begin
      rd8 = '0;
      if (hit_ctrl) begin
         rd8[ARM_BIT]     = armed_q;
         rd8[SEL_W-1:0]   = sel_q;
      end else if (hit_win) begin
         if (sel_q < SEL_W'(N_STEP)) rd8[FIELD_W-1:0] = fld_q[sel_q];
      end else if (hit_en) begin
         rd8[N_CH-1:0] = en_q;
      end
   end

   if (DATA_W > REG_W) begin : g_pad
      assign rdata = {{(DATA_W-REG_W){1'b0}}, rd8};
   end else begin : g_nopad
      assign rdata = rd8;
   end

   assign armed = armed_q;
   assign fld   = fld_q;
   assign en    = en_q;

   AST_WIN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && wr && hit_win) |=> $stable(fld_q)); // R3

endmodule

// File: rtl/dbgseq_arb.sv
module dbgseq_arb
   import dbgseq_pkg::*;
(
   input  seq_st_e              cur,
   input  logic [FIELD_W-1:0]   code,
   input  logic [N_CH-1:0]      hit,
   output logic                 go,
   output seq_st_e              dest
);

   logic [2*N_CH-1:0] route;
   logic [N_CH-1:0]   live;
   logic [N_CH-1:0]   fin;
   seq_st_e           cand [N_CH];

   assign route = route_of(code);

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      tgt_e tgt;
      assign tgt     = tgt_e'(route[2*i +: 2]);
      assign live[i] = hit[i] && (tgt != TGT_NONE);
      assign fin[i]  = live[i] && (tgt == TGT_FIN);
      assign cand[i] = resolve(cur, tgt);
   end

   always_comb begin
      go   = |live;
      dest = cur;
      if (|fin) begin
         dest = ST_FINAL;
      end else begin
         for (int k = N_CH - 1; k >= 0; k--) begin
            if (live[k]) dest = cand[k];
         end
      end
   end

endmodule

// File: rtl/dbgseq_fsm.sv
module dbgseq_fsm
   import dbgseq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     arm_set,
   input  logic     arm_clr,
   input  logic     go,
   input  seq_st_e  dest,
   output seq_st_e  state,
   output logic     final_flag,
   output logic     trig
);

   seq_st_e st_q;
   logic    fin_q, trig_q;
   logic    stepping;

   assign stepping = (st_q == ST_S1) || (st_q == ST_S2) || (st_q == ST_S3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fin_q  <= 1'b0;
         trig_q <= 1'b0;
      end else begin
         trig_q <= 1'b0;
         if (arm_clr) begin
            st_q <= ST_IDLE;
         end else if (arm_set) begin
            st_q  <= ST_S1;
            fin_q <= 1'b0;
         end else if (stepping && go) begin
            st_q <= dest;
            if (dest == ST_FINAL) begin
               fin_q  <= 1'b1;
               trig_q <= 1'b1;
            end
         end
      end
   end

   assign state      = st_q;
   assign final_flag = fin_q;
   assign trig       = trig_q;

   AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q |=> !trig_q); // R9
   AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FINAL && !arm_clr) |=> st_q == ST_FINAL); // R9
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_q && !arm_set) |=> fin_q); // R9
   AST_UNROUTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stepping && !go && !arm_set && !arm_clr) |=> $stable(st_q)); // R6

endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
   import dbgseq_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned CTRL_ADDR = 0,
   parameter int unsigned WIN_ADDR  = 1,
   parameter int unsigned EN_ADDR   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [2:0]        match_i,
   output logic              armed_o,
   output logic [2:0]        state_o,
   output logic              trig_o,
   output logic              final_o
);

   if (DATA_W < 8) begin : g_chk_w
      $error("dbgseq_top: DATA_W must be at least 8");
   end
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_chk_a
      $error("dbgseq_top: ADDR_W must lie in 2..16");
   end
   if (CTRL_ADDR == WIN_ADDR || CTRL_ADDR == EN_ADDR || WIN_ADDR == EN_ADDR) begin : g_chk_map
      $error("dbgseq_top: register addresses must differ");
   end

   logic                           armed, arm_set, arm_clr, go;
   logic [N_STEP-1:0][FIELD_W-1:0] fld;
   logic [N_CH-1:0]                en, hit;
   logic [FIELD_W-1:0]             code;
   seq_st_e                        state, dest;

   dbgseq_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .CTRL_ADDR(CTRL_ADDR), .WIN_ADDR(WIN_ADDR), .EN_ADDR(EN_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .armed(armed),
      .arm_set(arm_set), .arm_clr(arm_clr), .fld(fld), .en(en)
   );

   always_comb begin
      case (state)
         ST_S1:   code = fld[0];
         ST_S2:   code = fld[1];
         ST_S3:   code = fld[2];
         default: code = '0;
      endcase
   end

   assign hit = match_i & en;

   dbgseq_arb u_arb (
      .cur(state), .code(code), .hit(hit), .go(go), .dest(dest)
   );

   dbgseq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .arm_clr(arm_clr),
      .go(go), .dest(dest), .state(state), .final_flag(final_o), .trig(trig_o)
   );

   assign armed_o = armed;
   assign state_o = state;

   AST_ARMED_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      armed == (state != ST_IDLE)); // R4
   AST_ARM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      arm_set |=> state == ST_S1); // R4
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && hit == '0 && !arm_set && !arm_clr) |=> $stable(state)); // R7

endmodule

// File: tb/dbgseq_top_bench.sv
module dbgseq_top_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [2:0] match_i = '0;
   logic       armed_o, trig_o, final_o;
   logic [2:0] state_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dbgseq_top u_dbgseq_top (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .match_i(match_i),
      .armed_o(armed_o), .state_o(state_o), .trig_o(trig_o), .final_o(final_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // pulse matches for one cycle; returns after the edge that consumes them
   task automatic pulse(input logic [2:0] m);
      @(negedge clk);
      match_i = m;
      @(negedge clk);
      match_i = '0;
   endtask

   task automatic set_code(input logic [1:0] sel, input logic [3:0] c);
      wr(2'd0, {6'b0, sel});
      wr(2'd1, {4'b0, c});
   endtask

   task automatic arm();    wr(2'd0, 8'h80); endtask
   task automatic disarm(); wr(2'd0, 8'h00); endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 armed", armed_o, 0);
      chk("R1 state", state_o, 0);
      chk("R1 trig", trig_o, 0);
      chk("R1 final", final_o, 0);
      rd(2'd0, d); chk("R1 ctrl", d, 0);
      rd(2'd1, d); chk("R1 win", d, 0);
      rd(2'd2, d); chk("R1 en", d, 0);
   endtask

   task automatic t_regmap();
      logic [7:0] d;
      set_code(2'd0, 4'hD);
      set_code(2'd1, 4'h7);
      wr(2'd0, 8'h02); wr(2'd1, 8'hFB);
      wr(2'd2, 8'hFF);
      wr(2'd0, 8'h00); rd(2'd1, d); chk("R2 S1 code", d, 8'h0D);
      wr(2'd0, 8'h01); rd(2'd1, d); chk("R2 S2 code", d, 8'h07);
      wr(2'd0, 8'h02); rd(2'd1, d); chk("R2 S3 code upper zero", d, 8'h0B);
      rd(2'd0, d); chk("R2 ctrl readback", d, 8'h02);
      wr(2'd0, 8'h03); wr(2'd1, 8'h05); rd(2'd1, d); chk("R2 sel 11 reads 0", d, 0);
      rd(2'd2, d); chk("R2 enables", d, 8'h07);
      rd(2'd3, d); chk("R2 addr 3", d, 0);
   endtask

   task automatic t_arm_protect();
      logic [7:0] d;
      set_code(2'd0, 4'h1);
      wr(2'd0, 8'h80);
      chk("R4 armed", armed_o, 1);
      chk("R4 state S1", state_o, 1);
      wr(2'd1, 8'h09);
      rd(2'd1, d); chk("R3 locked", d, 8'h01);
      rd(2'd0, d); chk("R2 ctrl armed", d, 8'h80);
      disarm();
      chk("R4 disarm state", state_o, 0);
      chk("R4 disarm armed", armed_o, 0);
      wr(2'd1, 8'h09);
      rd(2'd1, d); chk("R3 idle write", d, 8'h09);
   endtask

   task automatic t_walk();
      set_code(2'd0, 4'h1);   // S1: ch0->S2
      set_code(2'd1, 4'h8);   // S2: ch1->S1, ch2->S3
      set_code(2'd2, 4'hB);   // S3: ch2->Final
      wr(2'd2, 8'h07);
      arm();
      pulse(3'b010); chk("R6 unrouted in S1", state_o, 1);
      pulse(3'b001); chk("R5 S1 ch0->S2", state_o, 2);
      pulse(3'b010); chk("R5 S2 ch1->S1", state_o, 1);
      pulse(3'b001); chk("R5 S1 ch0->S2 again", state_o, 2);
      pulse(3'b100); chk("R5 S2 ch2->S3", state_o, 3);
      pulse(3'b001); chk("R6 unrouted in S3", state_o, 3);
      @(negedge clk); match_i = 3'b100;
      @(negedge clk); match_i = '0;
      chk("R9 state final", state_o, 4);
      chk("R9 trig high", trig_o, 1);
      chk("R9 flag set", final_o, 1);
      @(negedge clk);
      chk("R9 trig one cycle", trig_o, 0);
      pulse(3'b111); chk("R9 final holds", state_o, 4);
      chk("R9 no retrigger", trig_o, 0);
      disarm();
      chk("R9 flag survives disarm", final_o, 1);
      arm();
      chk("R9 flag clears on arm", final_o, 0);
      chk("R4 rearm state", state_o, 1);
      disarm();
   endtask

   task automatic t_arbitrate();
      set_code(2'd0, 4'hD);
      arm();
      pulse(3'b011); chk("R8 ch0+ch1 final first", state_o, 4);
      disarm(); arm();
      pulse(3'b110); chk("R8 ch2 final beats ch1", state_o, 4);
      disarm(); arm();
      pulse(3'b010); chk("R5 1101 ch1->S2", state_o, 2);
      disarm();
      set_code(2'd0, 4'h7);   // ch0->S2, ch2->S3
      arm();
      pulse(3'b101); chk("R8 lowest channel wins", state_o, 2);
      disarm();
      set_code(2'd0, 4'hF);
      arm();
      pulse(3'b111); chk("R6 reserved code", state_o, 1);
      disarm();
   endtask

   task automatic t_enable();
      set_code(2'd0, 4'h3);   // ch2->S2
      wr(2'd2, 8'h03);
      arm();
      pulse(3'b100); chk("R7 disabled ch2", state_o, 1);
      wr(2'd2, 8'h07);
      pulse(3'b100); chk("R7 enabled ch2", state_o, 2);
      disarm();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_arm_protect();
      t_walk();
      t_arbitrate();
      t_enable();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule